// File: doc/BRIEF.md
# SIMD Floating-Point Exception Dispatcher

This block sits beside a SIMD floating-point datapath and decides, for each instruction, what the core does once the arithmetic has reported its exception conditions. It owns a control/status register that holds six sticky status flags and six mask bits. The conditions arrive in two phases. First come the operand checks made before any arithmetic: invalid operation, denormal operand and divide-by-zero. After that come the result checks: overflow, underflow and inexact result. Every raised condition sets its flag. The block then compares the raised conditions against their masks.

If every raised condition is masked, the instruction retires and the block marks that a default result is used. If any raised condition is unmasked, the block raises a single-cycle fault request and the instruction does not retire. The fault vector depends on an OS-support input. When OS support is present, the block requests the SIMD floating-point exception (vector 19). When it is absent, the block requests the invalid-opcode exception (vector 6). An unmasked operand-check condition faults at once, and the result-phase report for that instruction is never accepted.

The register can be written at any time. All outputs, and the register, change on the clock edge that follows the inputs that cause them.

Top module: `fpx_dispatch`

## Requirements
- R1: After reset the register reads 0x1F80: mask bits 7..12 are 1 and all flags and other bits are 0. faultReq, retire and useDefault are 0.
- R2: Flag bit positions: bit0 invalid, bit1 denormal, bit2 divide-by-zero, bit3 overflow, bit4 underflow, bit5 inexact. The operand phase reports preCond[0]=invalid, [1]=denormal, [2]=divide-by-zero. The result phase reports postCond[0]=overflow, [1]=underflow, [2]=inexact. An accepted condition sets its flag, visible on csrValue one cycle later.
- R3: Flags are sticky and only collect new conditions. A write stores csrWrData masked to bits 0..5 and 7..12. Conditions accepted in the same cycle are ORed onto the written value. Without a write, no flag ever clears.
- R4: The mask for the condition at flag bit k sits at bit 7+k. When every raised condition is masked, the instruction retires one cycle after its result phase, with useDefault=1 and no fault.
- R5: An accepted operand phase with any unmasked condition and osSupport=1 gives faultReq=1 with faultVec=19 for exactly one cycle, one cycle later, and no retire.
- R6: With osSupport=0, any unmasked fault uses faultVec=6 instead of 19. faultVec reads 0 whenever faultReq is 0.
- R7: After an operand-phase fault, result-phase inputs are ignored until the next instruction: no flag update, no fault and no retire.
- R8: An accepted result phase with an unmasked condition sets its flags, raises one fault pulse and does not retire.
- R9: An instruction that raises no condition in either phase retires with useDefault=0.
- R10: With both valid inputs low, no fault and no retire appear in the next cycle. An instruction never gives both a fault and a retire.
- R11: An operand phase (preValid) is accepted only while no instruction awaits its result phase. A result phase (postValid) is accepted only while one does. Inputs that are not accepted change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| preValid | input | 1 | Operand-phase report valid |
| preCond | input | 3 | Operand-phase conditions {div0, denormal, invalid} |
| postValid | input | 1 | Result-phase report valid |
| postCond | input | 3 | Result-phase conditions {inexact, underflow, overflow} |
| osSupport | input | 1 | 1 selects vector 19, 0 selects vector 6 |
| csrWrEn | input | 1 | Register write strobe |
| csrWrData | input | 16 | Register write value |
| csrValue | output | 16 | Current register contents |
| retire | output | 1 | Instruction retires this cycle |
| useDefault | output | 1 | Retiring instruction takes a default result |
| faultReq | output | 1 | Single-cycle fault request |
| faultVec | output | 8 | Fault vector, valid with faultReq |

## Verification
The embedded properties assume that the pipeline pairs each operand report with one later result report. They also assume that reports which do not fit the block's state are meant to be dropped. The random stimulus deliberately breaks this pairing, sending result reports while the block is idle and operand reports while it waits, so that the drop rule is exercised. A bench model tracks the same waiting state, so every cycle's expected outcome is defined. Masks, OS support and register writes are randomized, so all mask and vector combinations occur, both with and without a write in the same cycle as a report.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int PHASE_CONDS = 3;
  localparam int NUM_CONDS   = 2 * PHASE_CONDS;

  typedef struct packed {
    logic takePre;   // operand-phase conditions accepted this cycle
    logic takePost;  // result-phase conditions accepted this cycle
  } fpxStrobe_t;

  typedef enum logic {
    ST_IDLE      = 1'b0,
    ST_WAIT_POST = 1'b1
  } fpxState_t;
endpackage

// File: rtl/fpx_csr_path.sv
module fpx_csr_path
  import fpx_pkg::*;
#(
  parameter int CSR_W    = 16,
  parameter int FLAG_LSB = 0,
  parameter int MASK_LSB = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fpxStrobe_t             strobe,
  input  logic [PHASE_CONDS-1:0] preCond,
  input  logic [PHASE_CONDS-1:0] postCond,
  input  logic                   wrEn,
  input  logic [CSR_W-1:0]       wrData,
  output logic [NUM_CONDS-1:0]   maskBits,
  output logic [CSR_W-1:0]       csrValue
);
  localparam logic [CSR_W-1:0] FIELD_ONES = {{(CSR_W-NUM_CONDS){1'b0}}, {NUM_CONDS{1'b1}}};
  localparam logic [CSR_W-1:0] FLAG_FIELD = FIELD_ONES << FLAG_LSB;
  localparam logic [CSR_W-1:0] MASK_FIELD = FIELD_ONES << MASK_LSB;
  localparam logic [CSR_W-1:0] WR_LEGAL   = FLAG_FIELD | MASK_FIELD;

  logic [NUM_CONDS-1:0] condHit;
  logic [CSR_W-1:0]     flagSet;
  logic [CSR_W-1:0]     baseVal;
  logic [CSR_W-1:0]     csrQ;

  for (genvar g = 0; g < NUM_CONDS; g++) begin : g_cond
    if (g < PHASE_CONDS) begin : g_pre
      assign condHit[g] = strobe.takePre & preCond[g];
    end else begin : g_post
      assign condHit[g] = strobe.takePost & postCond[g-PHASE_CONDS];
    end
  end

  always_comb begin
    flagSet = {{(CSR_W-NUM_CONDS){1'b0}}, condHit} << FLAG_LSB;
    baseVal = wrEn ? (wrData & WR_LEGAL) : csrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) csrQ <= MASK_FIELD;
    else       csrQ <= baseVal | flagSet;
  end

  assign maskBits = csrQ[MASK_LSB +: NUM_CONDS];
  assign csrValue = csrQ;

  // R3: without a write no flag that was set can clear
  p_sticky_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((csrQ & $past(csrQ) & FLAG_FIELD) == ($past(csrQ) & FLAG_FIELD)));
endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_SIMD = 19,
  parameter int VEC_UD   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   preValid,
  input  logic [PHASE_CONDS-1:0] preCond,
  input  logic                   postValid,
  input  logic [PHASE_CONDS-1:0] postCond,
  input  logic                   osSupport,
  input  logic [NUM_CONDS-1:0]   maskBits,
  output fpxStrobe_t             strobe,
  output logic                   retire,
  output logic                   useDefault,
  output logic                   faultReq,
  output logic [VEC_W-1:0]       faultVec
);
  localparam logic [VEC_W-1:0] V_SIMD = VEC_W'(VEC_SIMD);
  localparam logic [VEC_W-1:0] V_UD   = VEC_W'(VEC_UD);

  fpxState_t            state;
  logic                 maskedHit;
  logic [PHASE_CONDS-1:0] preUnmasked, postUnmasked;
  logic                 preFault, postFault;
  logic [VEC_W-1:0]     vecSel;

  always_comb begin
    strobe.takePre  = (state == ST_IDLE) && preValid;
    strobe.takePost = (state == ST_WAIT_POST) && postValid;
    preUnmasked     = preCond  & ~maskBits[PHASE_CONDS-1:0];
    postUnmasked    = postCond & ~maskBits[NUM_CONDS-1:PHASE_CONDS];
    preFault        = strobe.takePre  && (|preUnmasked);
    postFault       = strobe.takePost && (|postUnmasked);
    vecSel          = osSupport ? V_SIMD : V_UD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      maskedHit  <= 1'b0;
      retire     <= 1'b0;
      useDefault <= 1'b0;
      faultReq   <= 1'b0;
      faultVec   <= '0;
    end else begin
      retire     <= 1'b0;
      useDefault <= 1'b0;
      faultReq   <= preFault || postFault;
      faultVec   <= (preFault || postFault) ? vecSel : '0;
      if (strobe.takePre && !preFault) begin
        state     <= ST_WAIT_POST;
        maskedHit <= |preCond;
      end
      if (strobe.takePost) begin
        state <= ST_IDLE;
        if (!postFault) begin
          retire     <= 1'b1;
          useDefault <= maskedHit || (|postCond);
        end
      end
    end
  end

  // R10: an instruction ends in a fault or a retire, never both
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(faultReq && retire));
  // R10: no valid report, no outcome next cycle
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!preValid && !postValid) |=> (!faultReq && !retire));
  // R6: vector follows the OS-support bit of the deciding cycle
  p_vector_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultReq |-> (faultVec == ($past(osSupport) ? V_SIMD : V_UD)));
  // R4: default result only on a retiring instruction
  p_default_retire_r4: assert property (@(posedge clk) disable iff (!rstN)
    useDefault |-> retire);
  // R11: the two phases are never accepted together
  p_phase_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takePre && strobe.takePost));
endmodule

// File: rtl/fpx_dispatch.sv
module fpx_dispatch
  import fpx_pkg::*;
#(
  parameter int CSR_W    = 16,
  parameter int FLAG_LSB = 0,
  parameter int MASK_LSB = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_SIMD = 19,
  parameter int VEC_UD   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             preValid,
  input  logic [2:0]       preCond,
  input  logic             postValid,
  input  logic [2:0]       postCond,
  input  logic             osSupport,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic [CSR_W-1:0] csrValue,
  output logic             retire,
  output logic             useDefault,
  output logic             faultReq,
  output logic [VEC_W-1:0] faultVec
);
  fpxStrobe_t           strobe;
  logic [NUM_CONDS-1:0] maskBits;

  fpx_csr_path #(.CSR_W(CSR_W), .FLAG_LSB(FLAG_LSB), .MASK_LSB(MASK_LSB)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preCond(preCond), .postCond(postCond),
    .wrEn(csrWrEn), .wrData(csrWrData), .maskBits(maskBits), .csrValue(csrValue)
  );

  fpx_ctrl #(.VEC_W(VEC_W), .VEC_SIMD(VEC_SIMD), .VEC_UD(VEC_UD)) u_ctrl (
    .clk(clk), .rstN(rstN), .preValid(preValid), .preCond(preCond),
    .postValid(postValid), .postCond(postCond), .osSupport(osSupport),
    .maskBits(maskBits), .strobe(strobe), .retire(retire), .useDefault(useDefault),
    .faultReq(faultReq), .faultVec(faultVec)
  );
endmodule

// File: tb/sim_fpx_dispatch.sv
`timescale 1ns/1ps
module sim_fpx_dispatch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic preValid = 0, postValid = 0, osSupport = 0, csrWrEn = 0;
  logic [2:0] preCond = 0, postCond = 0;
  logic [15:0] csrWrData = 0;
  logic [15:0] csrValue;
  logic retire, useDefault, faultReq;
  logic [7:0] faultVec;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  logic [15:0] mCsr;
  bit mWait, mHit;
  bit eFault, eRet, eDef;
  logic [7:0] eVec;

  always #2.5 clk = ~clk;

  fpx_dispatch u0 (
    .clk(clk), .rstN(rstN), .preValid(preValid), .preCond(preCond),
    .postValid(postValid), .postCond(postCond), .osSupport(osSupport),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrValue(csrValue),
    .retire(retire), .useDefault(useDefault), .faultReq(faultReq), .faultVec(faultVec)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected next register value from the requirements (R2, R3)
  function automatic logic [15:0] nextCsr(logic [15:0] cur, bit we, logic [15:0] wd,
                                          logic [5:0] newFlags);
    logic [15:0] base;
    base = we ? (wd & 16'h1FBF) : cur;
    return base | {10'd0, newFlags};
  endfunction

  // model one cycle, then apply the stimulus to the DUT and compare
  task automatic step(string tag, bit pv, logic [2:0] pc, bit qv, logic [2:0] qc,
                      bit os, bit we, logic [15:0] wd);
    logic [5:0] mask, nf;
    @(negedge clk);
    preValid = pv; preCond = pc; postValid = qv; postCond = qc;
    osSupport = os; csrWrEn = we; csrWrData = wd;
    mask = mCsr[12:7];
    nf = '0; eFault = 0; eRet = 0; eDef = 0; eVec = 8'd0;
    if (!mWait && pv) begin
      nf[2:0] = pc;
      if ((pc & ~mask[2:0]) != 0) begin
        eFault = 1; eVec = os ? 8'd19 : 8'd6;
      end else begin
        mWait = 1; mHit = (pc != 0);
      end
    end else if (mWait && qv) begin
      nf[5:3] = qc;
      mWait = 0;
      if ((qc & ~mask[5:3]) != 0) begin
        eFault = 1; eVec = os ? 8'd19 : 8'd6;
      end else begin
        eRet = 1; eDef = mHit || (qc != 0);
      end
    end
    mCsr = nextCsr(mCsr, we, wd, nf);
    @(posedge clk); #1;
    check({tag, " faultReq"}, faultReq, eFault);
    check({tag, " faultVec"}, faultVec, eVec);
    check({tag, " retire"}, retire, eRet);
    check({tag, " useDefault"}, useDefault, eDef);
    check({tag, " csr"}, csrValue, mCsr);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 3'd0, 0, 3'd0, 0, 0, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mCsr = 16'h1F80; mWait = 0; mHit = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 csr", csrValue, 16'h1F80);
    check("R1 faultReq", faultReq, 0);
    check("R1 retire", retire, 0);
    check("R1 useDefault", useDefault, 0);
    @(negedge clk); rstN = 1;

    idle("R10 idle");
    // unmask everything, OS support on: invalid operand faults with 19
    step("R3 write", 0, 3'd0, 0, 3'd0, 1, 1, 16'h0000);
    step("R5 pre fault 19", 1, 3'b001, 0, 3'd0, 1, 0, 16'd0);
    // R7: a result report now belongs to no instruction and is dropped
    step("R7 post ignored", 0, 3'd0, 1, 3'b001, 1, 0, 16'd0);
    step("R6 pre fault 6", 1, 3'b100, 0, 3'd0, 0, 0, 16'd0);
    // R2: flag positions 0 and 2 now set; clear with a write that masks all
    step("R3 clear", 0, 3'd0, 0, 3'd0, 0, 1, 16'h1F80);
    // R4: masked denormal then clean result -> retire with default
    step("R4 pre masked", 1, 3'b010, 0, 3'd0, 1, 0, 16'd0);
    step("R4 post retire", 0, 3'd0, 1, 3'b000, 1, 0, 16'd0);
    // R9: no conditions at all
    step("R9 pre clean", 1, 3'b000, 0, 3'd0, 1, 0, 16'd0);
    step("R9 post clean", 0, 3'd0, 1, 3'b000, 1, 0, 16'd0);
    // R8: unmask overflow only (mask bit 10 cleared)
    step("R8 write", 0, 3'd0, 0, 3'd0, 1, 1, 16'h1B80);
    step("R8 pre clean", 1, 3'b000, 0, 3'd0, 1, 0, 16'd0);
    step("R8 post fault", 0, 3'd0, 1, 3'b101, 1, 0, 16'd0);
    // R11: second operand report while waiting is dropped
    step("R11 pre first", 1, 3'b000, 0, 3'd0, 1, 1, 16'h0000);
    step("R11 pre dropped", 1, 3'b001, 0, 3'd0, 1, 0, 16'd0);
    step("R11 post", 0, 3'd0, 1, 3'b000, 1, 0, 16'd0);
    // R3: write in the same cycle as an accepted condition keeps the new flag
    step("R3 merge", 1, 3'b010, 0, 3'd0, 1, 1, 16'h1F80);
    step("R2 post flags", 0, 3'd0, 1, 3'b110, 1, 0, 16'd0);
    idle("R10 quiet");

    // constrained random traffic, fixed seed
    void'($urandom(32'h5eed));
    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [15:0] wd;
      we = ($urandom_range(0, 15) == 0);
      wd = 16'($urandom());
      step("R10 rand", $urandom_range(0, 2) != 0, 3'($urandom_range(0, 7)) & 3'($urandom()),
           $urandom_range(0, 2) != 0, 3'($urandom_range(0, 7)) & 3'($urandom()),
           1'($urandom()), we, wd);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule